// File: doc/BRIEF.md
# DDR2 Read Latency Return Scheduler

This block follows READ commands sent to a DDR2-style memory and marks the clock cycles in which their read data will come back. The total read latency is the sum of two whole-clock values: a CAS latency and a posted additive latency. Both are loaded together through a mode-register load strobe that carries a 3-bit field for each. Every accepted READ produces a four-beat, double-data-rate burst window that lasts two clocks. Several READs may be in flight at the same time, and READs spaced two clocks apart give one unbroken window.

An encoding that is reserved or out of range is never applied. It raises a configuration error, and any READ that arrives while that error stands is discarded and sets a sticky drop flag. The next legal load clears both flags. A legal load that arrives while reads are still in flight is held back until the pipeline is empty, so every burst already scheduled keeps the latency it was issued with.

Top module: `rd_latency_sched`

## Requirements
- R1: After a synchronous reset, dv_rise, dv_fall, beat_idx, cfg_err and drop_err are all 0, and the active latency is CAS 3 with additive 0 (a total of 3).
- R2: The field mr_cl is the CAS latency in clocks, and only the values 3, 4, 5 and 6 are legal. The field mr_al is the additive latency in clocks, and only the values 0 to 4 are legal. A legal pair sets the total latency to mr_cl + mr_al.
- R3: A READ sampled at clock edge n raises dv_rise at edge n+L, where L is the active total latency.
- R4: Each burst holds dv_rise and dv_fall high together for two consecutive clocks. beat_idx is 0 in the first clock and 2 in the second. It gives the rising-edge beat, and the falling-edge beat is beat_idx+1.
- R5: READs spaced two clocks apart produce a window with no gaps, in which beat_idx alternates 0, 2, 0, 2.
- R6: A load with mr_cl outside 3 to 6, or with mr_al above 4, sets cfg_err at the next edge and is not applied.
- R7: A READ sampled while cfg_err is 1 produces no burst, and it sets drop_err at the next edge. drop_err stays 1 until a legal load arrives.
- R8: A legal load clears both cfg_err and drop_err at the next edge.
- R9: A legal load made while reads are outstanding takes effect only once no reads remain in flight. READs issued before that point use the old latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_load | input | 1 | Mode-register load strobe |
| mr_cl | input | 3 | CAS latency field, in clocks |
| mr_al | input | 3 | Additive latency field, in clocks |
| rd_cmd | input | 1 | READ command registered on this edge |
| dv_rise | output | 1 | Rising-edge data beat expected |
| dv_fall | output | 1 | Falling-edge data beat expected |
| beat_idx | output | 2 | Rising-edge beat index within the burst (0 or 2) |
| cfg_err | output | 1 | Last load was reserved or illegal |
| drop_err | output | 1 | Sticky: a READ was dropped during a configuration error |

## Verification
The bench builds the block with its default parameters: CAS latency 3 to 6 and additive latency 0 to 4, which gives a delay line 10 stages deep. These values cover both ends of the latency range. The shortest case, 3 clocks, injects near the head of the line. The longest case, 10 clocks, injects at the last stage, and the bench uses it to hold a burst in flight while a new load waits. The bench also exercises a reserved CAS code and a reserved additive code, a READ that is dropped, and a back-to-back stream of READs at an intermediate latency.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  localparam int FLD_W = 3;

  typedef struct packed {
    logic [FLD_W-1:0] cl;
    logic [FLD_W-1:0] al;
  } lat_cfg_t;

  function automatic logic cfg_legal(input lat_cfg_t c, input int min_cl,
                                     input int max_cl, input int max_al);
    return (int'(c.cl) >= min_cl) && (int'(c.cl) <= max_cl) &&
           (int'(c.al) <= max_al);
  endfunction
endpackage

// File: rtl/rdl_cfg.sv
module rdl_cfg
  import rdl_pkg::*;
#(
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6,
  parameter int MAX_AL = 4,
  parameter int LAT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mr_load,
  input  logic [FLD_W-1:0] mr_cl,
  input  logic [FLD_W-1:0] mr_al,
  input  logic             rd_cmd,
  input  logic             idle,
  output logic             rd_ok,
  output logic [LAT_W-1:0] lat,
  output logic             cfg_err,
  output logic             drop_err
);
  lat_cfg_t act, pend, req;
  logic     pend_v;
  logic     req_legal;

  assign req       = '{cl: mr_cl, al: mr_al};
  assign req_legal = cfg_legal(req, MIN_CL, MAX_CL, MAX_AL);
  assign rd_ok     = rd_cmd && !cfg_err;
  assign lat       = LAT_W'(act.cl) + LAT_W'(act.al);

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= '{cl: FLD_W'(MIN_CL), al: '0};
      pend     <= '0;
      pend_v   <= 1'b0;
      cfg_err  <= 1'b0;
      drop_err <= 1'b0;
    end else begin
      if (mr_load) begin
        if (req_legal) begin
          pend     <= req;
          pend_v   <= 1'b1;
          cfg_err  <= 1'b0;
          drop_err <= 1'b0;
        end else begin
          pend_v  <= 1'b0;
          cfg_err <= 1'b1;
        end
      end else if (pend_v && idle && !rd_cmd) begin
        act    <= pend;
        pend_v <= 1'b0;
      end
      if (rd_cmd && cfg_err) drop_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rdl_delay.sv
module rdl_delay #(
  parameter int DEPTH = 10,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inject,
  input  logic [LAT_W-1:0] lat,
  output logic             head,
  output logic             busy
);
  logic [DEPTH-1:0] line;
  logic [DEPTH-1:0] tok;

  assign tok  = inject ? ({{(DEPTH-1){1'b0}}, 1'b1} << (lat - LAT_W'(1))) : '0;
  assign head = line[0];
  assign busy = |line;

  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else     line <= (line >> 1) | tok;
  end
endmodule

// File: rtl/rdl_beat.sv
module rdl_beat (
  input  logic       clk,
  input  logic       rst,
  input  logic       head,
  output logic       dv_rise,
  output logic       dv_fall,
  output logic [1:0] beat_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dv_rise  <= 1'b0;
      dv_fall  <= 1'b0;
      beat_idx <= 2'd0;
    end else if (head) begin
      dv_rise  <= 1'b1;
      dv_fall  <= 1'b1;
      beat_idx <= 2'd0;
    end else if (dv_rise && beat_idx == 2'd0) begin
      dv_rise  <= 1'b1;
      dv_fall  <= 1'b1;
      beat_idx <= 2'd2;
    end else begin
      dv_rise  <= 1'b0;
      dv_fall  <= 1'b0;
      beat_idx <= 2'd0;
    end
  end
endmodule

// File: rtl/rd_latency_sched.sv
module rd_latency_sched
  import rdl_pkg::*;
#(
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6,
  parameter int MAX_AL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mr_load,
  input  logic [FLD_W-1:0] mr_cl,
  input  logic [FLD_W-1:0] mr_al,
  input  logic             rd_cmd,
  output logic             dv_rise,
  output logic             dv_fall,
  output logic [1:0]       beat_idx,
  output logic             cfg_err,
  output logic             drop_err
);
  localparam int DEPTH = MAX_CL + MAX_AL;
  localparam int LAT_W = $clog2(DEPTH + 1);

  logic             rd_ok, head, busy, idle;
  logic [LAT_W-1:0] lat;

  assign idle = !busy && !dv_rise;

  rdl_cfg #(.MIN_CL(MIN_CL), .MAX_CL(MAX_CL), .MAX_AL(MAX_AL), .LAT_W(LAT_W)) u_cfg (
    .clk(clk), .rst(rst), .mr_load(mr_load), .mr_cl(mr_cl), .mr_al(mr_al),
    .rd_cmd(rd_cmd), .idle(idle), .rd_ok(rd_ok), .lat(lat),
    .cfg_err(cfg_err), .drop_err(drop_err)
  );

  rdl_delay #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_dly (
    .clk(clk), .rst(rst), .inject(rd_ok), .lat(lat), .head(head), .busy(busy)
  );

  rdl_beat u_beat (
    .clk(clk), .rst(rst), .head(head),
    .dv_rise(dv_rise), .dv_fall(dv_fall), .beat_idx(beat_idx)
  );
endmodule

// File: rtl/rdl_chk.sv
module rdl_chk #(
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6,
  parameter int MAX_AL = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       mr_load,
  input logic [2:0] mr_cl,
  input logic [2:0] mr_al,
  input logic       rd_cmd,
  input logic       dv_rise,
  input logic       dv_fall,
  input logic [1:0] beat_idx,
  input logic       cfg_err,
  input logic       drop_err
);
  logic bad_req;
  assign bad_req = (int'(mr_cl) < MIN_CL) || (int'(mr_cl) > MAX_CL) ||
                   (int'(mr_al) > MAX_AL);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dv_rise && !cfg_err && !drop_err));

  assert_beat_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (dv_rise && beat_idx == 2'd0) |=> (dv_rise && beat_idx == 2'd2));

  assert_edges_agree_R4: assert property (@(posedge clk) disable iff (rst)
    dv_rise == dv_fall);

  assert_even_index_R4: assert property (@(posedge clk) disable iff (rst)
    dv_rise |-> !beat_idx[0]);

  assert_bad_load_R6: assert property (@(posedge clk) disable iff (rst)
    (mr_load && bad_req) |=> cfg_err);

  assert_drop_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && cfg_err) |=> drop_err);

  assert_drop_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (drop_err && !mr_load) |=> drop_err);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (mr_load && !bad_req && !(rd_cmd && cfg_err)) |=> (!cfg_err && !drop_err));
endmodule

bind rd_latency_sched rdl_chk #(.MIN_CL(MIN_CL), .MAX_CL(MAX_CL), .MAX_AL(MAX_AL)) u_chk (
  .clk(clk), .rst(rst), .mr_load(mr_load), .mr_cl(mr_cl), .mr_al(mr_al),
  .rd_cmd(rd_cmd), .dv_rise(dv_rise), .dv_fall(dv_fall), .beat_idx(beat_idx),
  .cfg_err(cfg_err), .drop_err(drop_err)
);

// File: tb/sim_rd_latency_sched.sv
`timescale 1ns/1ps
module sim_rd_latency_sched;
  logic       clk = 1'b0, rst = 1'b1;
  logic       mr_load = 1'b0, rd_cmd = 1'b0;
  logic [2:0] mr_cl = 3'd0, mr_al = 3'd0;
  logic       dv_rise, dv_fall, cfg_err, drop_err;
  logic [1:0] beat_idx;

  int    cyc = 0, checks = 0, errors = 0, starts = 0, cur_lat = 3;
  int    exp_q[$];
  string tag_q[$];
  bit    want2 = 1'b0, done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rd_latency_sched u0 (
    .clk(clk), .rst(rst), .mr_load(mr_load), .mr_cl(mr_cl), .mr_al(mr_al),
    .rd_cmd(rd_cmd), .dv_rise(dv_rise), .dv_fall(dv_fall), .beat_idx(beat_idx),
    .cfg_err(cfg_err), .drop_err(drop_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one READ; a READ that should be accepted pushes its start cycle
  task automatic do_read(input bit accepted, input string req);
    rd_cmd = 1'b1;
    if (accepted) begin
      exp_q.push_back(cyc + 1 + cur_lat);
      tag_q.push_back(req);
    end
    tick(1);
    rd_cmd = 1'b0;
  endtask

  task automatic load(input int cl, input int al);
    mr_load = 1'b1; mr_cl = 3'(cl); mr_al = 3'(al);
    tick(1);
    mr_load = 1'b0;
  endtask

  // monitor: pops the expected start cycle of each burst and follows its beats
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (dv_rise !== dv_fall) chk(0, "R4 fall/rise", int'(dv_fall), int'(dv_rise));
      if (want2) begin
        chk(dv_rise === 1'b1 && beat_idx == 2'd2, "R4 second beat pair",
            int'(beat_idx), 2);
        want2 = 1'b0;
      end else if (dv_rise === 1'b1) begin
        starts++;
        chk(beat_idx == 2'd0, "R4 first beat index", int'(beat_idx), 0);
        if (exp_q.size() == 0) chk(0, "R7 unexpected burst", cyc, -1);
        else begin
          automatic int    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(cyc == e, t, cyc, e);
        end
        want2 = 1'b1;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog actual=%0d expected=0", cyc);
          $display("  CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    tick(3);
    rst = 1'b0;
    tick(1);
    chk(!dv_rise && !dv_fall && beat_idx == 0, "R1 outputs idle", int'(dv_rise), 0);
    chk(!cfg_err && !drop_err, "R1 flags clear", int'(cfg_err) + int'(drop_err), 0);
    do_read(1, "R1 R3 default latency 3");
    tick(8);

    load(5, 0); tick(2); cur_lat = 5;
    do_read(1, "R2 R3 CL5 AL0");
    tick(10);
    load(6, 4); tick(2); cur_lat = 10;
    do_read(1, "R2 R3 CL6 AL4 latency 10");
    tick(14);

    // R5: three READs two clocks apart at latency 5
    load(4, 1); tick(2); cur_lat = 5;
    begin
      automatic int first = cyc + 1 + cur_lat;
      do_read(1, "R5 stream 0"); tick(1);
      do_read(1, "R5 stream 1"); tick(1);
      do_read(1, "R5 stream 2");
      while (cyc != first) tick(1);
      for (int k = 0; k < 6; k++) begin
        chk(dv_rise === 1'b1, "R5 gapless window", int'(dv_rise), 1);
        tick(1);
      end
    end
    tick(6);

    // R6, R7: reserved CAS code
    begin
      automatic int s0 = starts;
      load(7, 0);
      chk(cfg_err === 1'b1, "R6 reserved CL flags error", int'(cfg_err), 1);
      chk(drop_err === 1'b0, "R7 no drop yet", int'(drop_err), 0);
      do_read(0, "R7");
      chk(drop_err === 1'b1, "R7 drop flag set", int'(drop_err), 1);
      tick(14);
      chk(starts == s0, "R7 dropped READ gives no burst", starts, s0);
      chk(drop_err === 1'b1, "R7 drop flag sticky", int'(drop_err), 1);
    end
    // R8: legal load clears flags
    load(3, 2);
    chk(!cfg_err && !drop_err, "R8 legal load clears flags",
        int'(cfg_err) + int'(drop_err), 0);
    tick(2); cur_lat = 5;
    do_read(1, "R8 read after recovery");
    tick(10);

    // R6: reserved additive code
    load(4, 5);
    chk(cfg_err === 1'b1, "R6 reserved AL flags error", int'(cfg_err), 1);
    load(6, 4); tick(2); cur_lat = 10;
    chk(cfg_err === 1'b0, "R8 cleared again", int'(cfg_err), 0);

    // R9: load while READs are in flight waits until drained
    do_read(1, "R9 in-flight read keeps latency 10");
    load(3, 0);
    do_read(1, "R9 read during pending load keeps latency 10");
    tick(16); cur_lat = 3;
    do_read(1, "R9 new latency 3 after drain");
    tick(12);
    chk(exp_q.size() == 0, "R9 all bursts seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule